// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer with Hold

This block is the digital side of a dual-slope integrating analog-to-digital converter. A divided system clock provides a free-running timebase. At a rate picked by a two-bit mode input, the block starts a conversion. First it closes the input switch for a fixed number of clock cycles, so the integrator charges from the signal. It then opens that switch and applies a reference of the opposite polarity. While the reference is applied, it counts clock cycles in decimal until the comparator shows that the charge has returned to its start level. The count that stands when the comparator changes state is the reading. That reading is loaded into a signed three-digit BCD result register.

The comparator level on the last integrate cycle gives the sign of the input, and so the polarity of the reference. A positive input has no trip within 1000 counts, or a negative input has none within 100 counts. In either case the phase is aborted and the matching overrange flag is raised. A hold mode keeps conversions running at the slow rate but freezes the result register. After hold, a fast request still runs at the slow rate until slow mode is selected again. The mode input is taken only when a conversion starts.

The analog integrator, comparator and reference sit outside the block. The result register drives a display decoder directly.

Top module: `dss_sequencer`

## Requirements
- R1: While reset is held, the switch enables and the overrange and sign flags are 0, and every result digit is 0.
- R2: Conversion starts, seen as rising edges of `int_en`, are FAST_TICKS×CLK_PER_TICK cycles apart when the latched mode is 2'b01. They are SLOW_TICKS×CLK_PER_TICK cycles apart when the latched mode is 2'b00 (slow) or 2'b11, which is treated as slow.
- R3: `int_en` stays high for exactly INT_CYCLES cycles. `ref_en` rises in the cycle in which `int_en` falls, and the two are never high together.
- R4: The comparator level in the last integrate cycle selects the sign: 1 means a positive input and gives `ref_pol`=1 throughout the de-integrate phase; 0 means a negative input and gives `ref_pol`=0.
- R5: A reading N is the number of de-integrate cycles that come before the first cycle in which the comparator differs from the captured sign. `ref_en` is then high for N+1 cycles. In the cycle after the trip, `res_bcd` holds N in BCD, hundreds in bits [11:8], tens in [7:4] and units in [3:0].
- R6: A negative reading sets `res_neg`=1 when N is nonzero and clears it when N is 0. Negative readings range from 0 to 99, so the hundreds digit is 0.
- R7: For a positive input with no trip during 1000 de-integrate cycles, `ref_en` falls after 1000 cycles. The result then shows `ovr_pos`=1, `ovr_neg`=0, `res_neg`=0 and every digit 4'hB.
- R8: For a negative input with no trip during 100 de-integrate cycles, `ref_en` falls after 100 cycles. The result then shows `ovr_neg`=1, `ovr_pos`=0 and every digit 4'hA.
- R9: A conversion started with mode 2'b10 (hold) is spaced at the slow rate and leaves the result register unchanged.
- R10: After a hold conversion, mode 2'b01 runs at the slow rate while still updating the result. It returns to fast spacing only after a conversion has started with mode 2'b00 or 2'b11.
- R11: The mode input is sampled only at a conversion start. A change made between two starts does not alter the spacing that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 slow, 01 fast, 10 hold, 11 slow |
| cmp_hi | input | 1 | Comparator level, 1 when the integrator is above the threshold |
| int_en | output | 1 | Input switch enable (integrate phase) |
| ref_en | output | 1 | Reference switch enable (de-integrate phase) |
| ref_pol | output | 1 | Reference polarity select, 1 for a positive input |
| res_bcd | output | NDIG*4 | Result digits, most significant digit in the top nibble |
| res_neg | output | 1 | Result is a nonzero negative reading |
| ovr_pos | output | 1 | Positive overrange |
| ovr_neg | output | 1 | Negative overrange |

## Verification
A start becomes visible one cycle after the timebase tick, as `int_en` rising. The bench stamps every start at the falling edge where `int_en` is first seen high, and compares the difference between stamps with the exact product of ticks and divider. `ref_en` follows exactly INT_CYCLES cycles after `int_en` rises. The comparator model counts falling edges from that point, so a reading of N toggles the comparator N edges after `ref_en` is first seen. The result is sampled at the falling edge where `ref_en` is first seen low, which is the same edge at which the register has loaded. Mode changes are applied right after a stamped start, so that the latching boundary is known exactly.

// File: rtl/dss_pkg.sv
package dss_pkg;

   typedef enum logic [1:0] {
      MODE_SLOW = 2'b00,
      MODE_FAST = 2'b01,
      MODE_HOLD = 2'b10,
      MODE_ALT  = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_INTEG = 2'd1,
      PH_DEINT = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      END_NONE = 2'd0,
      END_TRIP = 2'd1,
      END_OVP  = 2'd2,
      END_OVN  = 2'd3
   } end_e;

   localparam logic [3:0] CODE_OVP = 4'hB;
   localparam logic [3:0] CODE_OVN = 4'hA;
   localparam logic [3:0] DIGIT_MAX = 4'd9;

endpackage

// File: rtl/dss_rate_gen.sv
module dss_rate_gen
   import dss_pkg::*;
#(
   parameter int CLK_PER_TICK = 320,
   parameter int FAST_TICKS   = 8,
   parameter int SLOW_TICKS   = 196
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   output logic       start,
   output logic       hold_act
);

   localparam int PMAX = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
   localparam int PW   = $clog2(PMAX + 1);
   localparam logic [PW-1:0] FAST_LIM = PW'(FAST_TICKS - 1);
   localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_TICKS - 1);

   logic tick;

   generate
      if (CLK_PER_TICK == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(CLK_PER_TICK);
         localparam logic [DW-1:0] DIV_LAST = DW'(CLK_PER_TICK - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (div_q == DIV_LAST) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = (div_q == DIV_LAST);
      end
   endgenerate

   mode_e         mode_in;
   logic [PW-1:0] per_q;
   logic [PW-1:0] lim_q;
   logic [PW-1:0] lim_use;
   logic          stay_q;
   logic          stay_new;
   logic          fast_new;
   logic          hold_q;

   assign mode_in = mode_e'(mode);
   assign start   = tick && (per_q == '0);

   always_comb begin
      case (mode_in)
         MODE_HOLD: stay_new = 1'b1;
         MODE_FAST: stay_new = stay_q;
         default:   stay_new = 1'b0;
      endcase
      fast_new = (mode_in == MODE_FAST) && !stay_new;
      if (start) begin
         lim_use = fast_new ? FAST_LIM : SLOW_LIM;
      end else begin
         lim_use = lim_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q  <= '0;
         lim_q  <= SLOW_LIM;
         stay_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (tick) begin
            if (per_q == lim_use) begin
               per_q <= '0;
            end else begin
               per_q <= per_q + 1'b1;
            end
         end
         if (start) begin
            lim_q  <= lim_use;
            stay_q <= stay_new;
            hold_q <= (mode_in == MODE_HOLD);
         end
      end
   end

   assign hold_act = hold_q;

endmodule

// File: rtl/dss_bcd_count.sv
module dss_bcd_count
   import dss_pkg::*;
#(
   parameter int NDIG = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            inc,
   output logic [NDIG*4-1:0] digits,
   output logic            all_nine,
   output logic            low_nine
);

   logic [NDIG:0]   carry;
   logic [NDIG-1:0] nine;

   assign carry[0] = inc;

   generate
      for (genvar g = 0; g < NDIG; g++) begin : g_dig
         logic [3:0] d_q;
         assign nine[g]      = (d_q == DIGIT_MAX);
         assign carry[g + 1] = carry[g] & nine[g];
         assign digits[g*4 +: 4] = d_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               d_q <= '0;
            end else if (carry[g]) begin
               d_q <= nine[g] ? 4'd0 : d_q + 4'd1;
            end
         end
      end
   endgenerate

   assign all_nine = &nine;
   assign low_nine = &nine[NDIG-2:0];

endmodule

// File: rtl/dss_phase_ctl.sv
module dss_phase_ctl
   import dss_pkg::*;
#(
   parameter int INT_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cmp_hi,
   input  logic all_nine,
   input  logic low_nine,
   output logic int_en,
   output logic ref_en,
   output logic ref_pol,
   output logic cnt_clr,
   output logic cnt_inc,
   output end_e fin
);

   localparam int ICW = $clog2(INT_CYCLES);
   localparam logic [ICW-1:0] INT_LAST = ICW'(INT_CYCLES - 1);

   phase_e         ph_q;
   logic [ICW-1:0] icnt_q;
   logic           pos_q;
   logic           trip;

   assign trip = (cmp_hi != pos_q);

   always_comb begin
      fin = END_NONE;
      if (ph_q == PH_DEINT) begin
         if (trip) begin
            fin = END_TRIP;
         end else if (pos_q && all_nine) begin
            fin = END_OVP;
         end else if (!pos_q && low_nine) begin
            fin = END_OVN;
         end
      end
   end

   assign cnt_clr = (ph_q == PH_INTEG);
   assign cnt_inc = (ph_q == PH_DEINT) && (fin == END_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         icnt_q <= '0;
         pos_q  <= 1'b0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q   <= PH_INTEG;
                  icnt_q <= '0;
               end
            end
            PH_INTEG: begin
               if (icnt_q == INT_LAST) begin
                  pos_q <= cmp_hi;
                  ph_q  <= PH_DEINT;
               end else begin
                  icnt_q <= icnt_q + 1'b1;
               end
            end
            PH_DEINT: begin
               if (fin != END_NONE) begin
                  ph_q <= PH_IDLE;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign int_en  = (ph_q == PH_INTEG);
   assign ref_en  = (ph_q == PH_DEINT);
   assign ref_pol = pos_q;

endmodule

// File: rtl/dss_result.sv
module dss_result
   import dss_pkg::*;
#(
   parameter int NDIG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  end_e              fin,
   input  logic              pos,
   input  logic              hold,
   input  logic [NDIG*4-1:0] digits,
   output logic [NDIG*4-1:0] res_bcd,
   output logic              res_neg,
   output logic              ovr_pos,
   output logic              ovr_neg
);

   localparam logic [NDIG*4-1:0] FILL_OVP = {NDIG{CODE_OVP}};
   localparam logic [NDIG*4-1:0] FILL_OVN = {NDIG{CODE_OVN}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_bcd <= '0;
         res_neg <= 1'b0;
         ovr_pos <= 1'b0;
         ovr_neg <= 1'b0;
      end else if (!hold) begin
         case (fin)
            END_TRIP: begin
               res_bcd <= digits;
               res_neg <= !pos && (digits != '0);
               ovr_pos <= 1'b0;
               ovr_neg <= 1'b0;
            end
            END_OVP: begin
               res_bcd <= FILL_OVP;
               res_neg <= 1'b0;
               ovr_pos <= 1'b1;
               ovr_neg <= 1'b0;
            end
            END_OVN: begin
               res_bcd <= FILL_OVN;
               res_neg <= 1'b0;
               ovr_pos <= 1'b0;
               ovr_neg <= 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dss_sequencer.sv
module dss_sequencer
   import dss_pkg::*;
#(
   parameter int CLK_PER_TICK = 320,
   parameter int FAST_TICKS   = 8,
   parameter int SLOW_TICKS   = 196,
   parameter int INT_CYCLES   = 1000,
   parameter int NDIG         = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              cmp_hi,
   output logic              int_en,
   output logic              ref_en,
   output logic              ref_pol,
   output logic [NDIG*4-1:0] res_bcd,
   output logic              res_neg,
   output logic              ovr_pos,
   output logic              ovr_neg
);

   localparam int FULL_SCALE = 10 ** NDIG;
   localparam int FAST_CYC   = FAST_TICKS * CLK_PER_TICK;

   initial begin
      assert (NDIG >= 2) else $error("NDIG must be at least 2");
      assert (INT_CYCLES >= 2) else $error("INT_CYCLES must be at least 2");
      assert (CLK_PER_TICK >= 1 && FAST_TICKS >= 1) else $error("timebase must be nonzero");
      assert (SLOW_TICKS >= FAST_TICKS) else $error("slow spacing below fast spacing");
      assert (INT_CYCLES + FULL_SCALE + 2 < FAST_CYC)
         else $error("a conversion does not fit inside the fast spacing");
   end

   logic              start;
   logic              hold_act;
   logic              cnt_clr;
   logic              cnt_inc;
   logic              all_nine;
   logic              low_nine;
   logic [NDIG*4-1:0] cnt_digits;
   end_e              fin;

   dss_rate_gen #(
      .CLK_PER_TICK (CLK_PER_TICK),
      .FAST_TICKS   (FAST_TICKS),
      .SLOW_TICKS   (SLOW_TICKS)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .start    (start),
      .hold_act (hold_act)
   );

   dss_phase_ctl #(
      .INT_CYCLES (INT_CYCLES)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmp_hi   (cmp_hi),
      .all_nine (all_nine),
      .low_nine (low_nine),
      .int_en   (int_en),
      .ref_en   (ref_en),
      .ref_pol  (ref_pol),
      .cnt_clr  (cnt_clr),
      .cnt_inc  (cnt_inc),
      .fin      (fin)
   );

   dss_bcd_count #(
      .NDIG (NDIG)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cnt_clr),
      .inc      (cnt_inc),
      .digits   (cnt_digits),
      .all_nine (all_nine),
      .low_nine (low_nine)
   );

   dss_result #(
      .NDIG (NDIG)
   ) u_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .fin     (fin),
      .pos     (ref_pol),
      .hold    (hold_act),
      .digits  (cnt_digits),
      .res_bcd (res_bcd),
      .res_neg (res_neg),
      .ovr_pos (ovr_pos),
      .ovr_neg (ovr_neg)
   );

endmodule

// File: rtl/dss_sequencer_chk.sv
module dss_sequencer_chk #(
   parameter int NDIG = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              int_en,
   input logic              ref_en,
   input logic [NDIG*4-1:0] res_bcd,
   input logic              res_neg,
   input logic              ovr_pos,
   input logic              ovr_neg,
   input logic              hold_act
);

   AST_SWITCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(int_en && ref_en)); // R3

   AST_INT_TO_REF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_en) |-> ref_en); // R3

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovr_pos && ovr_neg)); // R7

   AST_NEG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_neg |-> (!ovr_pos && !ovr_neg && res_bcd[NDIG*4-1 -: 4] == 4'd0)); // R6

   AST_OVP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_pos |-> (res_bcd == {NDIG{4'hB}})); // R7

   AST_OVN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_neg |-> (res_bcd == {NDIG{4'hA}})); // R8

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      hold_act |=> ($stable(res_bcd) && $stable(res_neg) && $stable(ovr_pos) && $stable(ovr_neg))); // R9

   generate
      for (genvar g = 0; g < NDIG; g++) begin : g_dchk
         AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
            !(ovr_pos || ovr_neg) |-> (res_bcd[g*4 +: 4] <= 4'd9)); // R5
      end
   endgenerate

endmodule

bind dss_sequencer dss_sequencer_chk #(.NDIG(NDIG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .int_en   (int_en),
   .ref_en   (ref_en),
   .res_bcd  (res_bcd),
   .res_neg  (res_neg),
   .ovr_pos  (ovr_pos),
   .ovr_neg  (ovr_neg),
   .hold_act (hold_act)
);

// File: tb/dss_sequencer_bench.sv
`timescale 1ns/1ps
module dss_sequencer_bench;

   localparam int CPT   = 320;
   localparam int FT    = 8;
   localparam int ST    = 16;
   localparam int INTC  = 1000;
   localparam int ND    = 3;
   localparam int FAST_GAP = FT * CPT;
   localparam int SLOW_GAP = ST * CPT;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      mode = 2'b01;
   logic            cmp_hi = 1'b1;
   logic            int_en, ref_en, ref_pol, res_neg, ovr_pos, ovr_neg;
   logic [ND*4-1:0] res_bcd;

   int  checks = 0;
   int  failures = 0;
   int  cyc = 0;
   bit  finished = 1'b0;

   logic [11:0] last_bcd = '0;
   logic        last_neg = 1'b0;
   logic        last_ovp = 1'b0;
   logic        last_ovn = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dss_sequencer #(
      .CLK_PER_TICK (CPT),
      .FAST_TICKS   (FT),
      .SLOW_TICKS   (ST),
      .INT_CYCLES   (INTC),
      .NDIG         (ND)
   ) u_dss_sequencer (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .cmp_hi  (cmp_hi),
      .int_en  (int_en),
      .ref_en  (ref_en),
      .ref_pol (ref_pol),
      .res_bcd (res_bcd),
      .res_neg (res_neg),
      .ovr_pos (ovr_pos),
      .ovr_neg (ovr_neg)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] to_bcd(input int v);
      return {4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
   endfunction

   task automatic wait_start();
      while (int_en) @(negedge clk);
      while (!int_en) @(negedge clk);
   endtask

   task automatic measure_gap(input int exp, input string req);
      int t0;
      wait_start();
      t0 = cyc;
      wait_start();
      check(req, "start spacing", cyc - t0, exp);
   endtask

   // n < 0: comparator never trips
   task automatic run_conv(input bit pos, input int n, input bit held, input string req);
      int ic;
      int hc;
      int exp_hc;
      wait_start();
      cmp_hi = pos;
      ic = 1;
      @(negedge clk);
      while (int_en) begin
         ic++;
         @(negedge clk);
      end
      check("R3", "integrate length", ic, INTC);
      check("R3", "ref_en after integrate", int'(ref_en), 1);
      check("R4", "reference polarity", int'(ref_pol), int'(pos));
      hc = 1;
      if (n >= 0) begin
         for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hc++;
         end
         cmp_hi = !pos;
      end
      @(negedge clk);
      while (ref_en) begin
         hc++;
         @(negedge clk);
      end
      if (n >= 0) exp_hc = n + 1;
      else exp_hc = pos ? 1000 : 100;
      check(req, "de-integrate length", hc, exp_hc);
      if (!held) begin
         if (n >= 0) begin
            last_bcd = to_bcd(n);
            last_neg = !pos && (n != 0);
            last_ovp = 1'b0;
            last_ovn = 1'b0;
         end else begin
            last_bcd = pos ? 12'hBBB : 12'hAAA;
            last_neg = 1'b0;
            last_ovp = pos;
            last_ovn = !pos;
         end
      end
      check(req, "res_bcd", int'(res_bcd), int'(last_bcd));
      check(req, "res_neg", int'(res_neg), int'(last_neg));
      check(req, "ovr_pos", int'(ovr_pos), int'(last_ovp));
      check(req, "ovr_neg", int'(ovr_neg), int'(last_ovn));
   endtask

   task automatic t_reset();
      repeat (5) @(negedge clk);
      check("R1", "int_en in reset", int'(int_en), 0);
      check("R1", "ref_en in reset", int'(ref_en), 0);
      check("R1", "res_bcd in reset", int'(res_bcd), 0);
      check("R1", "flags in reset", int'({res_neg, ovr_pos, ovr_neg}), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_readings();
      run_conv(1'b1, 456, 1'b0, "R5");
      run_conv(1'b0, 37,  1'b0, "R6");
      run_conv(1'b1, 0,   1'b0, "R5");
      run_conv(1'b1, 999, 1'b0, "R5");
      run_conv(1'b0, 99,  1'b0, "R6");
      run_conv(1'b0, 0,   1'b0, "R6");
   endtask

   task automatic t_overrange();
      run_conv(1'b1, -1, 1'b0, "R7");
      run_conv(1'b0, -1, 1'b0, "R8");
   endtask

   task automatic t_rates();
      int t0;
      measure_gap(FAST_GAP, "R2");
      // R11: change between starts leaves the running spacing alone
      wait_start();
      t0 = cyc;
      mode = 2'b00;
      wait_start();
      check("R11", "spacing after mid-period change", cyc - t0, FAST_GAP);
      t0 = cyc;
      wait_start();
      check("R11", "slow spacing from next start", cyc - t0, SLOW_GAP);
      mode = 2'b11;
      wait_start();
      t0 = cyc;
      wait_start();
      check("R2", "mode 11 spacing", cyc - t0, SLOW_GAP);
   endtask

   task automatic t_hold();
      mode = 2'b01;
      wait_start();
      run_conv(1'b1, 123, 1'b0, "R9");
      mode = 2'b10;
      run_conv(1'b1, 777, 1'b1, "R9");
      measure_gap(SLOW_GAP, "R9");
      check("R9", "held res_bcd", int'(res_bcd), int'(to_bcd(123)));
   endtask

   task automatic t_after_hold();
      mode = 2'b01;
      measure_gap(SLOW_GAP, "R10");
      run_conv(1'b1, 250, 1'b0, "R10");
      mode = 2'b00;
      wait_start();
      mode = 2'b01;
      measure_gap(FAST_GAP, "R10");
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_readings();
      t_overrange();
      t_rates();
      t_hold();
      t_after_hold();
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete");
      summary();
   end

endmodule